// File: doc/BRIEF.md
# Edge-Capture Discrete Input Register

This block takes a bank of asynchronous discrete input lines (16 by default) and presents four views of each one at the same time. The raw view is the pin state as it arrives. The synchronized view is the pin re-timed to the system clock through a flop chain. The pulse view is high for exactly one clock at each rising edge of the synchronized signal. The sticky view is a latch bit that a rising edge sets and only software clears.

The synchronized, pulse and sticky views come out on dedicated output pins for neighbouring logic. Software reaches the block through a plain 32-bit register with single-cycle read and write strobes. A read strobe captures the raw pins in the low half of the word and the sticky bits in the high half. The captured word comes back one clock later with a valid flag. A write strobe carries a clear mask in its low half, and every sticky bit at a 1 position in the mask is cleared.

The register port is a control port, not a stream. It has no back-pressure: every strobe is taken in the cycle it is seen. The system clock is 100 MHz.

Top module: `eci_capture_reg`

## Requirements
- R1: While `rst_n` is low, and at the first clock after it goes high, `sync_o`, `pulse_o`, `latch_o`, `rd_valid` and `rd_data` are all zero, whatever the state of `din`.
- R2: `sync_o[i]` equals the value `din[i]` had SYNC_STAGES rising clock edges earlier (2 by default).
- R3: `pulse_o[i]` is 1 for exactly the one clock in which `sync_o[i]` has just gone from 0 to 1, and is 0 at all other times.
- R4: One clock after `pulse_o[i]` is 1, `latch_o[i]` is 1. It stays 1 until a clear for that bit.
- R5: A clock edge that sees `rd_en` high makes `rd_valid` 1 for the next cycle. In that cycle `rd_data[15:0]` holds `din` and `rd_data[31:16]` holds `latch_o`, both as they were at that edge. Bit i of each half belongs to input i. Without `rd_en`, `rd_valid` is 0.
- R6: A clock edge that sees `wr_en` high clears `latch_o[i]` for every i where `wr_data[i]` is 1. Bits where the mask is 0 keep their value. A mask of 0x0000FFFF clears all bits, and 0x00000001 clears bit 0 only.
- R7: If a pulse and a clear meet on the same bit at the same edge, the bit ends up set.
- R8: `wr_data[31:16]` has no effect on any output.
- R9: A falling edge on an input produces no pulse and does not set its latch bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, 100 MHz |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | W (16) | Asynchronous discrete inputs |
| sync_o | output | W (16) | Inputs re-timed to `clk` |
| pulse_o | output | W (16) | One-clock pulse per synchronized rising edge |
| latch_o | output | W (16) | Sticky rising-edge latch bits |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 2W (32) | Write word; low half is the clear mask |
| rd_en | input | 1 | Register read strobe |
| rd_data | output | 2W (32) | Read word: latches high, raw pins low |
| rd_valid | output | 1 | High for the cycle after a read strobe |

## Verification
The assertions assume that `din`, `wr_en`, `wr_data` and `rd_en` hold known values at each clock edge and that none of them changes within the setup window of that edge. In hardware, a raw input can be caught mid-transition, and the synchronizer is there to absorb that. The model of R2 and R5 that the checker keeps is only exact when the input is sampled cleanly. The stimulus drives every input a quarter period after the rising edge and holds each level for at least one full cycle, so every edge sees a settled value.

// File: rtl/eci_pkg.sv
package eci_pkg;
  localparam int unsigned ECI_DEF_WIDTH  = 16;
  localparam int unsigned ECI_DEF_STAGES = 2;

  // Clear mask taken from the low half of a write word; upper half dropped.
  function automatic logic [ECI_DEF_WIDTH-1:0] eci_mask_of(
      input logic                       en,
      input logic [ECI_DEF_WIDTH-1:0]   lo);
    return en ? lo : '0;
  endfunction
endpackage

// File: rtl/eci_sync.sv
module eci_sync #(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out,
  output logic [W-1:0] sync_prev
);
  localparam int unsigned DEPTH = STAGES + 1;

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [DEPTH-1:0] chain_q;
    always_ff @(posedge clk) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[DEPTH-2:0], async_in[b]};
    end
    assign sync_out[b]  = chain_q[STAGES-1];
    assign sync_prev[b] = chain_q[STAGES];
  end
endmodule

// File: rtl/eci_edge.sv
module eci_edge #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] prev,
  output logic [W-1:0] rise
);
  always_comb rise = cur & ~prev;
endmodule

// File: rtl/eci_latch.sv
module eci_latch #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_in,
  input  logic [W-1:0] clr_in,
  output logic [W-1:0] sticky
);
  logic [W-1:0] sticky_q;

  // Set wins over clear so an edge arriving with a clear is kept.
  always_ff @(posedge clk) begin
    if (!rst_n) sticky_q <= '0;
    else        sticky_q <= (sticky_q & ~clr_in) | set_in;
  end

  assign sticky = sticky_q;
endmodule

// File: rtl/eci_regif.sv
module eci_regif #(
  parameter int unsigned W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [W-1:0]   raw_in,
  input  logic [W-1:0]   sticky_in,
  input  logic           wr_en,
  input  logic [2*W-1:0] wr_data,
  input  logic           rd_en,
  output logic [W-1:0]   clr_mask,
  output logic [2*W-1:0] rd_data,
  output logic           rd_valid
);
  localparam int unsigned DW = 2 * W;

  logic [DW-1:0] rd_data_q;
  logic          rd_valid_q;
  logic          unused_hi;

  assign unused_hi = ^wr_data[DW-1:W];
  assign clr_mask  = wr_en ? wr_data[W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= rd_en;
      if (rd_en) rd_data_q <= {sticky_in, raw_in};
    end
  end

  assign rd_data  = rd_data_q;
  assign rd_valid = rd_valid_q;
endmodule

// File: rtl/eci_capture_reg.sv
module eci_capture_reg #(
  parameter int unsigned W      = eci_pkg::ECI_DEF_WIDTH,
  parameter int unsigned STAGES = eci_pkg::ECI_DEF_STAGES
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [W-1:0]   din,
  output logic [W-1:0]   sync_o,
  output logic [W-1:0]   pulse_o,
  output logic [W-1:0]   latch_o,
  input  logic           wr_en,
  input  logic [2*W-1:0] wr_data,
  input  logic           rd_en,
  output logic [2*W-1:0] rd_data,
  output logic           rd_valid
);
  logic [W-1:0] sync_prev;
  logic [W-1:0] clr_mask;

  eci_sync #(.W(W), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(din),
    .sync_out(sync_o), .sync_prev(sync_prev)
  );

  eci_edge #(.W(W)) u_edge (
    .cur(sync_o), .prev(sync_prev), .rise(pulse_o)
  );

  eci_latch #(.W(W)) u_latch (
    .clk(clk), .rst_n(rst_n), .set_in(pulse_o),
    .clr_in(clr_mask), .sticky(latch_o)
  );

  eci_regif #(.W(W)) u_regif (
    .clk(clk), .rst_n(rst_n), .raw_in(din), .sticky_in(latch_o),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .clr_mask(clr_mask), .rd_data(rd_data), .rd_valid(rd_valid)
  );
endmodule

// File: rtl/eci_capture_sva.sv
module eci_capture_sva #(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic [W-1:0]   din,
  input logic [W-1:0]   sync_o,
  input logic [W-1:0]   pulse_o,
  input logic [W-1:0]   latch_o,
  input logic           wr_en,
  input logic [2*W-1:0] wr_data,
  input logic           rd_en,
  input logic [2*W-1:0] rd_data,
  input logic           rd_valid
);
  // Independent history of din and a count of cycles since reset.
  logic [W-1:0] hist_q [STAGES];
  int unsigned  since_rst;

  always_ff @(posedge clk) begin
    if (!rst_n) since_rst <= 0;
    else if (since_rst < STAGES + 1) since_rst <= since_rst + 1;
  end

  always_ff @(posedge clk) begin
    hist_q[0] <= din;
    for (int k = 1; k < STAGES; k++) hist_q[k] <= hist_q[k-1];
  end

  // R2
  a_r2_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= STAGES) |-> (sync_o == hist_q[STAGES-1]));

  // R3
  a_r3_pulse_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o == (sync_o & ~$past(sync_o)));

  a_r3_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_o != '0) |=> ((pulse_o & $past(pulse_o)) == '0));

  // R4, R7
  a_r4_latch_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 1) |-> ((latch_o & $past(pulse_o)) == $past(pulse_o)));

  // R9: a latch bit only rises after a pulse
  a_r9_rise_needs_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 1) |-> ((latch_o & ~$past(latch_o) & ~$past(pulse_o)) == '0));

  // R6, R8: a latch bit only falls where the mask's low half had a 1
  a_r6_clear_by_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 1) |->
      ((~latch_o & $past(latch_o) &
        ~($past(wr_en) ? $past(wr_data[W-1:0]) : {W{1'b0}})) == '0));

  // R5
  a_r5_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  a_r5_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);

  a_r5_word_layout: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> (rd_data == {$past(latch_o), $past(din)}));
endmodule

bind eci_capture_reg eci_capture_sva #(.W(W), .STAGES(STAGES)) u_sva (.*);

// File: tb/eci_capture_reg_test.sv
module eci_capture_reg_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [W-1:0]   din = '0;
  logic [W-1:0]   sync_o, pulse_o, latch_o;
  logic           wr_en = 1'b0;
  logic [2*W-1:0] wr_data = '0;
  logic           rd_en = 1'b0;
  logic [2*W-1:0] rd_data;
  logic           rd_valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  eci_capture_reg uut (
    .clk(clk), .rst_n(rst_n), .din(din), .sync_o(sync_o),
    .pulse_o(pulse_o), .latch_o(latch_o), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .rd_valid(rd_valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic cyc();
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [31:0] val);
    wr_en = 1'b1; wr_data = val; cyc(); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic do_read(input logic [31:0] exp, input string req);
    rd_en = 1'b1; cyc(); rd_en = 1'b0;
    check({req, " rd_valid"}, {31'd0, rd_valid}, 32'd1);
    check({req, " rd_data"}, rd_data, exp);
    cyc();
    check("R5 valid drops", {31'd0, rd_valid}, 32'd0);
  endtask

  task automatic test_reset();
    din = 16'hA5A5; rd_en = 1'b1;
    repeat (3) cyc();
    check("R1 sync in reset", {16'd0, sync_o}, 32'd0);
    check("R1 pulse in reset", {16'd0, pulse_o}, 32'd0);
    check("R1 latch in reset", {16'd0, latch_o}, 32'd0);
    check("R1 rd_valid in reset", {31'd0, rd_valid}, 32'd0);
    rd_en = 1'b0; din = '0;
    rst_n = 1'b1; cyc();
    check("R1 rd_data after reset", rd_data, 32'd0);
    check("R1 latch after reset", {16'd0, latch_o}, 32'd0);
    repeat (3) cyc();
  endtask

  task automatic test_rise_views();
    din = 16'h0008; cyc();
    check("R2 sync not yet", {16'd0, sync_o}, 32'd0);
    cyc();
    check("R2 sync after two", {16'd0, sync_o}, 32'h0008);
    check("R3 pulse high", {16'd0, pulse_o}, 32'h0008);
    check("R4 latch not yet", {16'd0, latch_o}, 32'd0);
    cyc();
    check("R3 pulse one cycle", {16'd0, pulse_o}, 32'd0);
    check("R4 latch set", {16'd0, latch_o}, 32'h0008);
    din = '0; repeat (4) cyc();
    check("R4 latch held", {16'd0, latch_o}, 32'h0008);
  endtask

  task automatic test_fall_ignored();
    do_write(32'h0000FFFF);
    din = 16'h0100; repeat (4) cyc();
    do_write(32'h0000FFFF);
    check("R6 clear all", {16'd0, latch_o}, 32'd0);
    din = 16'h0000; cyc(); cyc();
    check("R9 no pulse on fall", {16'd0, pulse_o}, 32'd0);
    check("R9 sync fell", {16'd0, sync_o}, 32'd0);
    cyc();
    check("R9 latch stays clear", {16'd0, latch_o}, 32'd0);
  endtask

  task automatic test_read_format();
    din = 16'h8001; repeat (4) cyc();
    din = 16'h1234;
    do_read(32'h80011234, "R5 read word");
  endtask

  task automatic test_clear_mask();
    din = 16'hFFFF; repeat (4) cyc();
    din = '0; repeat (3) cyc();
    check("R4 all latched", {16'd0, latch_o}, 32'h0000FFFF);
    do_write(32'h00000001);
    check("R6 clear bit0 only", {16'd0, latch_o}, 32'h0000FFFE);
    do_write(32'h0000F000);
    check("R6 clear top nibble", {16'd0, latch_o}, 32'h00000FFE);
    do_write(32'hFFFF0000);
    check("R8 upper half ignored", {16'd0, latch_o}, 32'h00000FFE);
    do_read(32'h0FFE0000, "R8 read after upper write");
    do_write(32'h0000FFFF);
    check("R6 clear all", {16'd0, latch_o}, 32'd0);
  endtask

  task automatic test_set_priority();
    din = 16'h0040; repeat (4) cyc();
    din = 16'h0020; cyc(); cyc();
    check("R7 pulse present", {16'd0, pulse_o}, 32'h0020);
    do_write(32'h00000060);
    check("R7 set wins, other cleared", {16'd0, latch_o}, 32'h00000020);
    din = '0; repeat (3) cyc();
    do_write(32'h0000FFFF);
  endtask

  initial begin
    fork
      begin
        test_reset();
        test_rise_views();
        test_fall_ignored();
        test_read_format();
        test_clear_mask();
        test_set_priority();
        done = 1'b1;
      end
      begin
        repeat (100000) @(posedge clk);
        if (!done) begin
          errors++;
          $display("FAIL watchdog actual=timeout expected=completion");
        end
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule